// File: doc/BRIEF.md
# Selective Re-Dispatch Queue

This block keeps a copy of every in-flight instruction, from dispatch until commit, so that a chosen subset can be sent to the issue queue a second time. It is used after a mispredicted branch has been recovered without squashing the control-independent code behind it. In that case some younger instructions read registers whose physical tags have just changed. The rename repair presents each changed tag as an old/new pair. Every live entry that reads the old tag takes the new one and is marked. Marked entries leave oldest-first through a narrow, deeply pipelined output. Each entry that leaves broadcasts its destination tag back into the queue, which marks its consumers in turn. The instructions sent out are therefore only the data-dependent slice of the repair.

Entries are kept in allocation order in a circular buffer. A new entry is written at the tail. Commit frees the entry at the head. A squash moves the tail back to a given slot. Sending an entry again does not remove it, so the same entry can be re-dispatched after several later repairs. The internal wakeup loop works only on the queue's own tags and is separate from the main scheduler.

Top module: `redispatch_queue`

## Requirements
- R1: An allocation writes the entry at the slot shown on `alloc_idx`, and that index then advances by one (mod DEPTH). When DEPTH entries are live, `queue_full` is 1 and an allocation has no effect.
- R2: An entry stays in the queue after it has been re-dispatched. It leaves only through commit or squash, and it can be re-dispatched again by a later repair.
- R3: A rewrite replaces the old tag with the new tag in every source field of every live entry, and marks each entry that changed. Entries that do not read the old tag are left unchanged and unmarked.
- R4: When an entry is selected, its destination tag marks every other live entry that reads that tag. Transitive consumers are sent in successive cycles.
- R5: At most LANES (2) entries are selected per cycle, oldest first counted from the head. Lane 0 always carries the older entry, including when the buffer wraps past slot DEPTH-1.
- R6: An entry marked at clock edge k is presented on the output during the cycle after edge k+STAGES (STAGES = 8). With a consumer one hop down the chain, that consumer follows one cycle later.
- R7: While `rd_valid` is 1 and `rd_ready` is 0, the output lanes hold steady and selection stops. Entries marked during the stall are sent once the stall ends.
- R8: A squash sets the allocation slot to `squash_idx` and drops every entry from that slot up to the old tail. Dropped entries are never re-dispatched. A squash in the same cycle as an allocation or commit overrides both.
- R9: A commit frees the head entry. A freed entry is not re-dispatched, even when a later rewrite names one of its tags.
- R10: Sending an entry clears its mark, so one mark yields exactly one re-dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Write a new entry at the tail |
| alloc_src0 | input | TAG_W | First source tag of the new entry |
| alloc_src1 | input | TAG_W | Second source tag of the new entry |
| alloc_dst | input | TAG_W | Destination tag of the new entry |
| alloc_idx | output | IDX_W | Slot the next allocation uses |
| queue_full | output | 1 | All DEPTH slots are live |
| rw_valid | input | 1 | Apply a tag rewrite this cycle |
| rw_old | input | TAG_W | Tag to search for |
| rw_new | input | TAG_W | Replacement tag |
| commit_valid | input | 1 | Free the head entry |
| squash_valid | input | 1 | Roll the tail back |
| squash_idx | input | IDX_W | New tail slot after the squash |
| rd_valid | output | 1 | At least one output lane holds an entry |
| rd_ready | input | 1 | Downstream accepts all lanes this cycle |
| rd_lane_vld | output | LANES | Per-lane valid; lane 0 is the oldest |
| rd_idx | output | LANES x IDX_W | Queue slot of each lane |
| rd_src0 | output | LANES x TAG_W | First source tag as repaired |
| rd_src1 | output | LANES x TAG_W | Second source tag as repaired |
| rd_dst | output | LANES x TAG_W | Destination tag |

## Verification
The assertions take some things for granted about the inputs. `squash_idx` always names a slot between the head and the tail. A commit only arrives when an entry is live. No rewrite or squash touches the entry the output lanes are currently holding. The directed tasks keep within these rules: every squash slot is computed from the entries allocated so far, and the one commit happens while the queue is non-empty. Destination tags are chosen so that wakeup chains end where each scenario expects. Each scenario drives its rewrite, stall, squash or commit one cycle at a time, waits until the pipeline has drained, and then compares the ordered log of transfers against expected slots, tags and cycle numbers.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
   localparam int RDQ_DEPTH_DEF  = 16;
   localparam int RDQ_TAG_W_DEF  = 6;
   localparam int RDQ_LANES_DEF  = 2;
   localparam int RDQ_STAGES_DEF = 8;
endpackage

// File: rtl/rdq_pick.sv
module rdq_pick #(
   parameter int DEPTH = 16,
   parameter int LANES = 2,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]            mark,
   input  logic [IDX_W-1:0]            head,
   output logic [LANES-1:0]            hit,
   output logic [LANES-1:0][IDX_W-1:0] idx
);
   // oldest-first scan starting at head
   always_comb begin
      int taken;
      logic [IDX_W-1:0] pos;
      hit   = '0;
      idx   = '0;
      taken = 0;
      for (int i = 0; i < DEPTH; i++) begin
         pos = head + IDX_W'(i);
         if (mark[pos] && taken < LANES) begin
            hit[taken] = 1'b1;
            idx[taken] = pos;
            taken      = taken + 1;
         end
      end
   end
endmodule

// File: rtl/rdq_wake.sv
module rdq_wake #(
   parameter int DEPTH = 16,
   parameter int TAG_W = 6,
   parameter int LANES = 2
) (
   input  logic [DEPTH-1:0]            live,
   input  logic [DEPTH-1:0][TAG_W-1:0] src0,
   input  logic [DEPTH-1:0][TAG_W-1:0] src1,
   input  logic                        rw_valid,
   input  logic [TAG_W-1:0]            rw_old,
   input  logic [LANES-1:0]            bc_vld,
   input  logic [LANES-1:0][TAG_W-1:0] bc_tag,
   output logic [DEPTH-1:0]            hit0,
   output logic [DEPTH-1:0]            hit1,
   output logic [DEPTH-1:0]            wake
);
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic any_bc;
      always_comb begin
         any_bc = 1'b0;
         for (int l = 0; l < LANES; l++)
            any_bc = any_bc | (bc_vld[l] & ((src0[e] == bc_tag[l]) | (src1[e] == bc_tag[l])));
      end
      assign hit0[e] = live[e] & rw_valid & (src0[e] == rw_old);
      assign hit1[e] = live[e] & rw_valid & (src1[e] == rw_old);
      assign wake[e] = live[e] & any_bc;
   end
endmodule

// File: rtl/rdq_pipe.sv
module rdq_pipe #(
   parameter int STAGES = 8,
   parameter int LANES  = 2,
   parameter int W      = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        in_vld,
   input  logic [LANES-1:0][W-1:0] in_data,
   output logic                    in_ready,
   output logic [LANES-1:0]        out_vld,
   output logic [LANES-1:0][W-1:0] out_data,
   input  logic                    out_ready
);
   logic [STAGES-1:0][LANES-1:0]        vld_q;
   logic [STAGES-1:0][LANES-1:0][W-1:0] dat_q;
   logic                                adv;

   assign adv      = !(|vld_q[STAGES-1]) || out_ready;
   assign in_ready = adv;
   assign out_vld  = vld_q[STAGES-1];
   assign out_data = dat_q[STAGES-1];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[s] <= '0;
            dat_q[s] <= '0;
         end else if (adv) begin
            if (s == 0) begin
               vld_q[s] <= in_vld;
               dat_q[s] <= in_data;
            end else begin
               vld_q[s] <= vld_q[s-1];
               dat_q[s] <= dat_q[s-1];
            end
         end
      end
   end

   AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((|out_vld) && !out_ready) |=> ($stable(out_vld) && $stable(out_data))); // R7
endmodule

// File: rtl/redispatch_queue.sv
module redispatch_queue
   import rdq_pkg::*;
#(
   parameter int DEPTH  = RDQ_DEPTH_DEF,
   parameter int TAG_W  = RDQ_TAG_W_DEF,
   parameter int LANES  = RDQ_LANES_DEF,
   parameter int STAGES = RDQ_STAGES_DEF,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        alloc_valid,
   input  logic [TAG_W-1:0]            alloc_src0,
   input  logic [TAG_W-1:0]            alloc_src1,
   input  logic [TAG_W-1:0]            alloc_dst,
   output logic [IDX_W-1:0]            alloc_idx,
   output logic                        queue_full,
   input  logic                        rw_valid,
   input  logic [TAG_W-1:0]            rw_old,
   input  logic [TAG_W-1:0]            rw_new,
   input  logic                        commit_valid,
   input  logic                        squash_valid,
   input  logic [IDX_W-1:0]            squash_idx,
   output logic                        rd_valid,
   input  logic                        rd_ready,
   output logic [LANES-1:0]            rd_lane_vld,
   output logic [LANES-1:0][IDX_W-1:0] rd_idx,
   output logic [LANES-1:0][TAG_W-1:0] rd_src0,
   output logic [LANES-1:0][TAG_W-1:0] rd_src1,
   output logic [LANES-1:0][TAG_W-1:0] rd_dst
);
   localparam int CNT_W = IDX_W + 1;
   localparam int PW    = IDX_W + 3 * TAG_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LANES < 1 || LANES > DEPTH) begin : g_bad_lanes
      $error("LANES must lie between 1 and DEPTH");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("STAGES must be at least 1");
   end

   logic [DEPTH-1:0]            valid_q, mark_q;
   logic [DEPTH-1:0][TAG_W-1:0] src0_q, src1_q, dst_q;
   logic [IDX_W-1:0]            head_q, tail_q;
   logic [CNT_W-1:0]            count_q;

   logic [LANES-1:0]            pick_hit, sel_go;
   logic [LANES-1:0][IDX_W-1:0] pick_idx;
   logic [LANES-1:0][TAG_W-1:0] bc_tag;
   logic [LANES-1:0][PW-1:0]    pin_data, pout_data;
   logic [DEPTH-1:0]            hit0, hit1, wake, sent;
   logic                        adv, do_alloc, do_commit;
   logic [IDX_W-1:0]            sq_age;

   assign queue_full = (count_q == CNT_W'(DEPTH));
   assign alloc_idx  = tail_q;
   assign do_alloc   = alloc_valid && !queue_full;
   assign do_commit  = commit_valid && (count_q != '0);
   assign sq_age     = squash_idx - head_q;

   rdq_pick #(.DEPTH(DEPTH), .LANES(LANES)) u_pick (
      .mark(mark_q), .head(head_q), .hit(pick_hit), .idx(pick_idx));

   assign sel_go = pick_hit & {LANES{adv}};

   always_comb begin
      sent = '0;
      for (int l = 0; l < LANES; l++) begin
         bc_tag[l]   = dst_q[pick_idx[l]];
         pin_data[l] = {pick_idx[l], src0_q[pick_idx[l]], src1_q[pick_idx[l]], dst_q[pick_idx[l]]};
         if (sel_go[l]) sent[pick_idx[l]] = 1'b1;
      end
   end

   rdq_wake #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LANES(LANES)) u_wake (
      .live(valid_q), .src0(src0_q), .src1(src1_q),
      .rw_valid(rw_valid), .rw_old(rw_old),
      .bc_vld(sel_go), .bc_tag(bc_tag),
      .hit0(hit0), .hit1(hit1), .wake(wake));

   rdq_pipe #(.STAGES(STAGES), .LANES(LANES), .W(PW)) u_pipe (
      .clk(clk), .rst_n(rst_n),
      .in_vld(sel_go), .in_data(pin_data), .in_ready(adv),
      .out_vld(rd_lane_vld), .out_data(pout_data), .out_ready(rd_ready));

   assign rd_valid = |rd_lane_vld;
   for (genvar l = 0; l < LANES; l++) begin : g_out
      assign {rd_idx[l], rd_src0[l], rd_src1[l], rd_dst[l]} = pout_data[l];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         mark_q  <= '0;
         src0_q  <= '0;
         src1_q  <= '0;
         dst_q   <= '0;
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (hit0[i]) src0_q[i] <= rw_new;
            if (hit1[i]) src1_q[i] <= rw_new;
         end
         mark_q <= (mark_q & ~sent) | hit0 | hit1 | (wake & ~sent);
         if (squash_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (IDX_W'(IDX_W'(i) - head_q) >= sq_age) begin
                  valid_q[i] <= 1'b0;
                  mark_q[i]  <= 1'b0;
               end
            end
            tail_q  <= squash_idx;
            count_q <= CNT_W'(sq_age);
         end else begin
            if (do_commit) begin
               valid_q[head_q] <= 1'b0;
               mark_q[head_q]  <= 1'b0;
               head_q          <= head_q + 1'b1;
            end
            if (do_alloc) begin
               valid_q[tail_q] <= 1'b1;
               mark_q[tail_q]  <= 1'b0;
               src0_q[tail_q]  <= alloc_src0;
               src1_q[tail_q]  <= alloc_src1;
               dst_q[tail_q]   <= alloc_dst;
               tail_q          <= tail_q + 1'b1;
            end
            count_q <= count_q + CNT_W'(do_alloc) - CNT_W'(do_commit);
         end
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH)); // R1
   AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_full && alloc_valid && !commit_valid && !squash_valid) |=> (alloc_idx == $past(alloc_idx))); // R1
   AST_MARK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_q & ~valid_q) == '0); // R2
   AST_SQUASH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |=> (alloc_idx == $past(squash_idx))); // R8
   AST_SENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_go[0] && !rw_valid && !squash_valid) |=> !mark_q[$past(pick_idx[0])]); // R10
   AST_STALL_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |-> (sel_go == '0)); // R7
   if (LANES > 1) begin : g_order
      logic [IDX_W-1:0] age0, age1;
      assign age0 = pick_idx[0] - head_q;
      assign age1 = pick_idx[1] - head_q;
      AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
         pick_hit[1] |-> (pick_hit[0] && (age1 > age0))); // R5
   end
endmodule

// File: tb/tb_redispatch_queue.sv
`timescale 1ns/1ps
module tb_redispatch_queue;
   localparam int DEPTH = 16, TAG_W = 6, LANES = 2, STAGES = 8, IDX_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_valid = 0, rw_valid = 0, commit_valid = 0, squash_valid = 0, rd_ready = 1;
   logic [TAG_W-1:0] alloc_src0 = 0, alloc_src1 = 0, alloc_dst = 0, rw_old = 0, rw_new = 0;
   logic [IDX_W-1:0] squash_idx = 0, alloc_idx;
   logic queue_full, rd_valid;
   logic [LANES-1:0] rd_lane_vld;
   logic [LANES-1:0][IDX_W-1:0] rd_idx;
   logic [LANES-1:0][TAG_W-1:0] rd_src0, rd_src1, rd_dst;

   redispatch_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LANES(LANES), .STAGES(STAGES)) dut (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_src0(alloc_src0),
      .alloc_src1(alloc_src1), .alloc_dst(alloc_dst), .alloc_idx(alloc_idx),
      .queue_full(queue_full), .rw_valid(rw_valid), .rw_old(rw_old), .rw_new(rw_new),
      .commit_valid(commit_valid), .squash_valid(squash_valid), .squash_idx(squash_idx),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_lane_vld(rd_lane_vld), .rd_idx(rd_idx),
      .rd_src0(rd_src0), .rd_src1(rd_src1), .rd_dst(rd_dst));

   always #10 clk = ~clk; // 50 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_cmp = 0, n_bad = 0, log_n = 0;
   int log_idx [256], log_lane [256], log_cyc [256], log_src0 [256], log_src1 [256];

   // record every transfer just before the edge that takes it
   always @(negedge clk) begin
      #9;
      if (rst_n && rd_valid && rd_ready)
         for (int l = 0; l < LANES; l++)
            if (rd_lane_vld[l] && log_n < 256) begin
               log_idx[log_n]  = int'(rd_idx[l]);
               log_lane[log_n] = l;
               log_cyc[log_n]  = cyc;
               log_src0[log_n] = int'(rd_src0[l]);
               log_src1[log_n] = int'(rd_src1[l]);
               log_n = log_n + 1;
            end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic alloc_one(input int s0, input int s1, input int d);
      @(negedge clk);
      alloc_valid = 1; alloc_src0 = TAG_W'(s0); alloc_src1 = TAG_W'(s1); alloc_dst = TAG_W'(d);
      @(negedge clk);
      alloc_valid = 0;
   endtask

   task automatic rewrite(input int o, input int n, output int c0);
      @(negedge clk);
      rw_valid = 1; rw_old = TAG_W'(o); rw_new = TAG_W'(n);
      @(posedge clk); #1 c0 = cyc;
      @(negedge clk);
      rw_valid = 0;
   endtask

   task automatic t_reset();
      check("R1", "reset alloc_idx", int'(alloc_idx), 0);
      check("R1", "reset queue_full", int'(queue_full), 0);
      check("R6", "reset rd_valid", int'(rd_valid), 0);
   endtask

   task automatic t_alloc();
      alloc_one(1, 2, 10);  alloc_one(10, 3, 11); alloc_one(4, 5, 12);
      alloc_one(11, 6, 13); alloc_one(4, 8, 14);  alloc_one(4, 9, 15);
      check("R1", "alloc_idx after six", int'(alloc_idx), 6);
      idle(12);
      check("R3", "no output without rewrite", log_n, 0);
   endtask

   task automatic t_chain();
      int b, c0;
      b = log_n;
      rewrite(1, 20, c0);
      idle(24);
      check("R4", "chain length", log_n - b, 3);
      check("R3", "first wave slot", log_idx[b], 0);
      check("R3", "first wave new tag", log_src0[b], 20);
      check("R6", "first wave cycle", log_cyc[b], c0 + STAGES);
      check("R4", "second hop slot", log_idx[b+1], 1);
      check("R4", "second hop cycle", log_cyc[b+1], c0 + STAGES + 1);
      check("R4", "third hop slot", log_idx[b+2], 3);
      check("R4", "third hop cycle", log_cyc[b+2], c0 + STAGES + 2);
   endtask

   task automatic t_two_lane();
      int b, c0;
      b = log_n;
      rewrite(4, 22, c0);
      idle(24);
      check("R5", "sent count", log_n - b, 3);
      check("R5", "lane0 oldest slot", log_idx[b], 2);
      check("R5", "lane0 number", log_lane[b], 0);
      check("R5", "lane1 slot", log_idx[b+1], 4);
      check("R5", "lane1 number", log_lane[b+1], 1);
      check("R5", "pair same cycle", log_cyc[b+1], c0 + STAGES);
      check("R5", "third waits a cycle", log_cyc[b+2], c0 + STAGES + 1);
      check("R5", "third slot", log_idx[b+2], 5);
   endtask

   task automatic t_stall();
      int b, c0, c1;
      b = log_n;
      @(negedge clk); rd_ready = 0;
      rewrite(5, 24, c0);
      idle(12);
      check("R7", "held valid", int'(rd_valid), 1);
      check("R7", "held slot", int'(rd_idx[0]), 2);
      check("R3", "held src1 repaired", int'(rd_src1[0]), 24);
      rewrite(3, 29, c1);
      idle(12);
      check("R7", "held slot later", int'(rd_idx[0]), 2);
      check("R7", "no transfer in stall", log_n - b, 0);
      @(negedge clk); rd_ready = 1;
      idle(30);
      check("R7", "after stall count", log_n - b, 3);
      check("R7", "after stall first", log_idx[b], 2);
      check("R7", "marked in stall sent", log_idx[b+1], 1);
      check("R4", "its consumer", log_idx[b+2], 3);
   endtask

   task automatic t_squash();
      int b, c0;
      @(negedge clk); squash_valid = 1; squash_idx = 4'd3;
      @(negedge clk); squash_valid = 0;
      check("R8", "alloc_idx after squash", int'(alloc_idx), 3);
      b = log_n;
      rewrite(9, 25, c0);
      idle(20);
      check("R8", "squashed not sent", log_n - b, 0);
      rewrite(20, 26, c0);
      idle(24);
      check("R8", "chain cut at squash", log_n - b, 2);
      check("R2", "resent slot 0", log_idx[b], 0);
      check("R2", "resent new tag", log_src0[b], 26);
      check("R4", "consumer slot 1", log_idx[b+1], 1);
   endtask

   task automatic t_commit();
      int b, c0;
      @(negedge clk); commit_valid = 1;
      @(negedge clk); commit_valid = 0;
      b = log_n;
      rewrite(26, 27, c0);
      idle(20);
      check("R9", "committed not sent", log_n - b, 0);
      rewrite(10, 28, c0);
      idle(24);
      check("R9", "live entry sent", log_n - b, 1);
      check("R9", "live slot", log_idx[b], 1);
      check("R3", "live new tag", log_src0[b], 28);
      idle(20);
      check("R10", "sent once", log_n - b, 1);
   endtask

   task automatic t_full_wrap();
      int b, c0;
      for (int k = 0; k < 14; k++) begin
         @(negedge clk);
         alloc_valid = 1;
         alloc_src0 = TAG_W'((k >= 12) ? 30 : 33);
         alloc_src1 = TAG_W'(34);
         alloc_dst  = TAG_W'(40 + k);
      end
      @(negedge clk); alloc_valid = 0;
      check("R1", "full flag", int'(queue_full), 1);
      check("R1", "alloc_idx at full", int'(alloc_idx), 1);
      alloc_one(30, 30, 60);
      check("R1", "alloc ignored when full", int'(alloc_idx), 1);
      check("R1", "still full", int'(queue_full), 1);
      b = log_n;
      rewrite(30, 31, c0);
      idle(24);
      check("R5", "wrap pair count", log_n - b, 2);
      check("R5", "wrap lane0 older", log_idx[b], 15);
      check("R5", "wrap lane1 younger", log_idx[b+1], 0);
      check("R5", "wrap pair cycle", log_cyc[b+1], c0 + STAGES);
   endtask

   logic done = 0;
   initial begin
      #(200000 * 20);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_alloc();
      t_chain();
      t_two_lane();
      t_stall();
      t_squash();
      t_commit();
      t_full_wrap();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule